// File: doc/BRIEF.md
# Speculative Store Forwarding Buffer

This block is a small direct-mapped buffer that lets stores and loads share data while the core runs ahead speculatively past a long-latency miss. A store that pseudo-retires in that mode writes its data word into the buffer together with its poison flag. The poison flag marks a value that depends on the outstanding miss. A later load in the same mode probes the buffer with its word address. On a hit the load gets the stored word and its poison flag, so a load that reads poisoned data becomes poisoned itself. On a miss the load reports no hit and takes its value from the ordinary memory path.

The buffer is allowed to be inexact. A store that maps to an occupied line replaces that line without any writeback. When the speculative mode ends, the core pulses the wipe input and every line is invalidated in one cycle. The probe is combinational, and the storage updates on the clock edge. A store and a load in the same cycle therefore never forward to each other.

Top module: `rac_store_cache`

## Requirements
- R1: After reset every line is invalid, so any enabled probe returns `ld_hit`=0.
- R2: A store to word address A makes a probe of A, from the next cycle on, return `ld_hit`=1 and the stored data word.
- R3: The poison flag given with a store is returned on `ld_inv` by a hitting probe. A later store to the same address replaces both the data and the flag, and may set the flag to 0.
- R4: A probe that misses drives `ld_hit`=0, `ld_inv`=0 and `ld_data`=0.
- R5: The line is selected by the low `RAC_IW` bits of the word address, and the remaining upper bits form the tag. A store to a different address with the same low bits replaces the older line. The older address then misses and the newer one hits.
- R6: A cycle with `wipe`=1 invalidates all lines, so every probe in the following cycle misses.
- R7: When `wipe` and `st_en` are both high in one cycle, the wipe wins and the store is dropped.
- R8: A probe in the same cycle as a store to the same line sees the line's earlier contents. The new contents are visible from the next cycle.
- R9: With `ld_en`=0 the block drives `ld_hit`=0, `ld_inv`=0 and `ld_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wipe | input | 1 | Invalidate all lines (end of speculative mode) |
| st_en | input | 1 | Pseudo-retired store write enable |
| st_addr | input | RAC_AW | Store word address |
| st_data | input | RAC_DW | Store data word |
| st_inv | input | 1 | Store poison flag |
| ld_en | input | 1 | Load probe enable |
| ld_addr | input | RAC_AW | Load word address |
| ld_hit | output | 1 | Probe found a valid matching line |
| ld_inv | output | 1 | Poison flag of the forwarded word |
| ld_data | output | RAC_DW | Forwarded data word |

## Verification
Some rules are checked on every cycle at the ports:
- a miss or an idle probe carries no poison and no data;
- nothing hits right after a wipe;
- a store is visible with its exact data and flag in the cycle after it is written.

Other behaviours span several operations, so only the directed scenarios can show them:
- the tag comparison on conflicting addresses;
- the replacement of a line;
- clearing a poison flag by rewriting the line;
- the wipe-over-store priority;
- the old-contents result of a same-cycle store and probe.

// File: rtl/rac_pkg.sv
package rac_pkg;
    parameter int unsigned RAC_AW = 32;
    parameter int unsigned RAC_DW = 32;
    parameter int unsigned RAC_IW = 3;
    localparam int unsigned RAC_LINES = 1 << RAC_IW;
    localparam int unsigned RAC_TW = RAC_AW - RAC_IW;

    typedef struct packed {
        logic              vld;
        logic              inv;
        logic [RAC_TW-1:0] tag;
        logic [RAC_DW-1:0] data;
    } rac_line_t;

    typedef struct packed {
        logic              hit;
        logic              inv;
        logic [RAC_DW-1:0] data;
    } rac_rsp_t;

    function automatic logic [RAC_IW-1:0] line_of(input logic [RAC_AW-1:0] a);
        return a[RAC_IW-1:0];
    endfunction

    function automatic logic [RAC_TW-1:0] tag_of(input logic [RAC_AW-1:0] a);
        return a[RAC_AW-1:RAC_IW];
    endfunction
endpackage

// File: rtl/rac_line.sv
module rac_line
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic [RAC_TW-1:0] wr_tag,
    input  logic              wr_inv,
    input  logic [RAC_DW-1:0] wr_data,
    output rac_line_t         line_q
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            line_q.vld <= 1'b0;
        end else if (wr_en) begin
            line_q.vld <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q.inv  <= 1'b0;
            line_q.tag  <= '0;
            line_q.data <= '0;
        end else if (wr_en && !wipe) begin
            line_q.inv  <= wr_inv;
            line_q.tag  <= wr_tag;
            line_q.data <= wr_data;
        end
    end
endmodule

// File: rtl/rac_probe.sv
module rac_probe
    import rac_pkg::*;
(
    input  rac_line_t         lines [RAC_LINES],
    input  logic              ld_en,
    input  logic [RAC_AW-1:0] ld_addr,
    output rac_rsp_t          rsp
);
    rac_line_t sel;
    logic      match;

    always_comb begin
        sel   = lines[line_of(ld_addr)];
        match = ld_en && sel.vld && (sel.tag == tag_of(ld_addr));
        rsp   = '0;
        if (match) begin
            rsp.hit  = 1'b1;
            rsp.inv  = sel.inv;
            rsp.data = sel.data;
        end
    end
endmodule

// File: rtl/rac_store_cache.sv
module rac_store_cache
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              st_en,
    input  logic [RAC_AW-1:0] st_addr,
    input  logic [RAC_DW-1:0] st_data,
    input  logic              st_inv,
    input  logic              ld_en,
    input  logic [RAC_AW-1:0] ld_addr,
    output logic              ld_hit,
    output logic              ld_inv,
    output logic [RAC_DW-1:0] ld_data
);
    rac_line_t lines [RAC_LINES];
    rac_rsp_t  rsp;
    logic [RAC_IW-1:0] st_line;
    logic [RAC_TW-1:0] st_tag;

    assign st_line = line_of(st_addr);
    assign st_tag  = tag_of(st_addr);

    for (genvar g = 0; g < RAC_LINES; g++) begin : g_line
        logic sel_wr;
        assign sel_wr = st_en && (st_line == RAC_IW'(g));
        rac_line i_line (
            .clk     (clk),
            .rst     (rst),
            .wipe    (wipe),
            .wr_en   (sel_wr),
            .wr_tag  (st_tag),
            .wr_inv  (st_inv),
            .wr_data (st_data),
            .line_q  (lines[g])
        );
    end

    rac_probe i_probe (
        .lines   (lines),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .rsp     (rsp)
    );

    assign ld_hit  = rsp.hit;
    assign ld_inv  = rsp.inv;
    assign ld_data = rsp.data;
endmodule

// File: rtl/rac_store_cache_chk.sv
module rac_store_cache_chk
    import rac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wipe,
    input logic              st_en,
    input logic [RAC_AW-1:0] st_addr,
    input logic [RAC_DW-1:0] st_data,
    input logic              st_inv,
    input logic              ld_en,
    input logic [RAC_AW-1:0] ld_addr,
    input logic              ld_hit,
    input logic              ld_inv,
    input logic [RAC_DW-1:0] ld_data
);
    a_r4_miss_is_clean: assert property (@(posedge clk) disable iff (rst)
        !ld_hit |-> (!ld_inv && ld_data == '0));

    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !ld_en |-> !ld_hit);

    a_r6_wipe_all_miss: assert property (@(posedge clk) disable iff (rst)
        $past(wipe) |-> !ld_hit);

    a_r2_store_forwards: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st_en) && !$past(wipe) && ld_en && ld_addr == $past(st_addr))
        |-> (ld_hit && ld_data == $past(st_data) && ld_inv == $past(st_inv)));
endmodule

bind rac_store_cache rac_store_cache_chk i_chk (.*);

// File: tb/test_rac_store_cache.sv
module test_rac_store_cache;
    import rac_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, wipe = 0, st_en = 0, st_inv = 0, ld_en = 0;
    logic [RAC_AW-1:0] st_addr = '0, ld_addr = '0;
    logic [RAC_DW-1:0] st_data = '0;
    logic ld_hit, ld_inv;
    logic [RAC_DW-1:0] ld_data;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rac_store_cache i_rac_store_cache (.*);

    task automatic check(input string req, input logic eh, input logic ei, input logic [RAC_DW-1:0] ed);
        n_chk++;
        if (ld_hit !== eh || ld_inv !== ei || ld_data !== ed) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b inv=%0b data=%h, expected hit=%0b inv=%0b data=%h",
                     req, ld_hit, ld_inv, ld_data, eh, ei, ed);
        end
    endtask

    // Drive a store at a falling edge; it is written on the next rising edge.
    task automatic store(input logic [RAC_AW-1:0] a, input logic [RAC_DW-1:0] d, input logic i);
        @(negedge clk);
        ld_en = 0; st_en = 1; st_addr = a; st_data = d; st_inv = i;
        @(negedge clk);
        st_en = 0;
    endtask

    task automatic probe(input string req, input logic [RAC_AW-1:0] a,
                         input logic eh, input logic ei, input logic [RAC_DW-1:0] ed);
        ld_en = 1; ld_addr = a;
        #1 check(req, eh, ei, ed);
        ld_en = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        probe("R1", 32'h0, 0, 0, '0);
        probe("R1", 32'h7, 0, 0, '0);
    endtask

    task automatic t_forward();
        store(32'h100, 32'hCAFE_0001, 0);
        probe("R2", 32'h100, 1, 0, 32'hCAFE_0001);
        store(32'h203, 32'hBEEF_0003, 1);
        probe("R3", 32'h203, 1, 1, 32'hBEEF_0003);
        probe("R2", 32'h100, 1, 0, 32'hCAFE_0001);
        store(32'h203, 32'h1234_5678, 0);
        probe("R3", 32'h203, 1, 0, 32'h1234_5678);
    endtask

    task automatic t_miss();
        @(negedge clk);
        probe("R4", 32'h105, 0, 0, '0);
        ld_addr = 32'h100;
        #1 check("R9", 0, 0, '0);
    endtask

    task automatic t_conflict();
        store(32'h40, 32'hAAAA_0000, 1);
        probe("R5", 32'h40, 1, 1, 32'hAAAA_0000);
        probe("R5", 32'h48, 0, 0, '0);
        store(32'h48, 32'hBBBB_0000, 0);
        probe("R5", 32'h48, 1, 0, 32'hBBBB_0000);
        probe("R5", 32'h40, 0, 0, '0);
    endtask

    task automatic t_same_cycle();
        store(32'h61, 32'h0000_0011, 0);
        @(negedge clk);
        st_en = 1; st_addr = 32'h61; st_data = 32'h0000_0022; st_inv = 1;
        ld_en = 1; ld_addr = 32'h61;
        #1 check("R8", 1, 0, 32'h0000_0011);
        @(negedge clk);
        st_en = 0;
        #1 check("R8", 1, 1, 32'h0000_0022);
        ld_en = 0;
    endtask

    task automatic t_wipe();
        @(negedge clk);
        wipe = 1;
        @(negedge clk);
        wipe = 0;
        probe("R6", 32'h100, 0, 0, '0);
        probe("R6", 32'h48, 0, 0, '0);
        probe("R6", 32'h61, 0, 0, '0);
        @(negedge clk);
        wipe = 1; st_en = 1; st_addr = 32'h300; st_data = 32'h5555_5555; st_inv = 0;
        @(negedge clk);
        wipe = 0; st_en = 0;
        probe("R7", 32'h300, 0, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset();
        t_forward();
        t_miss();
        t_conflict();
        t_same_cycle();
        t_wipe();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule